// File: doc/BRIEF.md
# Streaming Coordinate-List Sparse Matrix-Vector Unit

This block computes its own slice of y = M·x for one partition of a sparse matrix held as a list of coordinates. Matrix entries arrive as wide packets of LANES slots. Each slot carries a row index, a column index, a value and a slot-valid bit, and the block takes one packet on every clock cycle without stalling. The dense vector x sits in LANES identical copies, one for each slot position. Slot i always reads copy i, so every slot fetches its operand in the same cycle and no two reads contend for a port.

Within a packet, the products that target the same row are merged before they reach the row store. This means each row gets at most one update per packet. The row store holds one running sum per row of the partition. The partition owns ROWS consecutive rows starting at global row ROW_BASE. A packet with its end-of-stream flag set starts write-back. A small state machine then walks the store in ascending order and packs SLOTS consecutive row results into each output word, with a mask that marks which rows received data. Words that carry no data are dropped, except the final word, which always goes out and is flagged as last. Each emitted word clears its rows, so the next stream starts from zero.

Top module: `spmv_coo_unit`

## Requirements
- R1: A write on the vector load port stores the word at that address in every copy. Slot i reads copy i at its column index, and all slots read in the same cycle.
- R2: The result for a row is the sum of val·x[col] over all of its accepted entries, taken modulo 2^DATA_W (unsigned wrap).
- R3: Accepted slots in one packet that share a row are summed together into a single contribution to that row.
- R4: A slot whose slot-valid bit is 0, or any slot of a packet presented without pkt_valid_i, contributes nothing and does not mark its row.
- R5: An entry is dropped if its row is outside [ROW_BASE, ROW_BASE+ROWS) or its column is not below VEC_DEPTH.
- R6: One packet is accepted per clock cycle with no stall, and contributions to a row accumulate across packets.
- R7: A packet flagged last starts write-back. Word w covers global rows ROW_BASE+w·SLOTS+k in slot k (slot k in bits [k·DATA_W +: DATA_W]), out_base_o is ROW_BASE+w·SLOTS, and words leave in ascending w.
- R8: Mask bit k is 1 exactly when the row in slot k received at least one accepted entry. Data in a slot whose mask bit is 0 is zero.
- R9: A word whose mask is all zero is not emitted unless it is the final word. The final word is always emitted, with out_last_o high.
- R10: Rows are cleared as their word is written back, so a following stream accumulates from zero.
- R11: After reset, out_valid_o and out_last_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vec_we_i | input | 1 | Vector load write enable |
| vec_waddr_i | input | $clog2(VEC_DEPTH) | Vector load address |
| vec_wdata_i | input | DATA_W | Vector load data |
| pkt_valid_i | input | 1 | Packet present this cycle |
| pkt_last_i | input | 1 | Packet ends the stream |
| pkt_lane_vld_i | input | LANES | Per-slot valid bits |
| pkt_row_i | input | LANES*IDX_W | Global row index per slot |
| pkt_col_i | input | LANES*IDX_W | Column index per slot |
| pkt_val_i | input | LANES*DATA_W | Matrix value per slot |
| out_valid_o | output | 1 | Output word valid |
| out_last_o | output | 1 | Final word of the write-back |
| out_base_o | output | IDX_W | Global row of slot 0 |
| out_mask_o | output | SLOTS | Rows present in the word |
| out_data_o | output | SLOTS*DATA_W | Packed row results |

## Verification
The bench builds the unit with five slots, a 16-entry vector, and a 20-row partition based at row 8, with 15 rows per output word. These values give two output words, and the second one is only partly populated. Row indices around both ends of the partition and out-of-range columns can therefore be hit, and a stream can touch only the upper word, which makes the empty-word skip observable. Directed streams cover same-row merging, padding slots and an empty stream. A long pseudo-random sweep then reloads the vector and sends streams of varied lengths, and every emitted word is compared against sums computed in the bench.

// File: rtl/spmv_pkg.sv
package spmv_pkg;
  typedef enum logic {WB_IDLE, WB_RUN} wb_state_e;

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/spmv_vec_replicas.sv
module spmv_vec_replicas #(
  parameter int LANES  = 5,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                    clk_i,
  input  logic                    we_i,
  input  logic [AW-1:0]           waddr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic [LANES*AW-1:0]     raddr_i,
  output logic [LANES*DATA_W-1:0] rdata_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_copy
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rd_q;
    always_ff @(posedge clk_i) begin
      if (we_i) mem_q[waddr_i] <= wdata_i;
      rd_q <= mem_q[raddr_i[g*AW +: AW]];
    end
    assign rdata_o[g*DATA_W +: DATA_W] = rd_q;
  end
endmodule

// File: rtl/spmv_lane_reduce.sv
module spmv_lane_reduce #(
  parameter int LANES  = 5,
  parameter int DATA_W = 32,
  parameter int RW     = 6
) (
  input  logic [LANES-1:0]        vld_i,
  input  logic [LANES*RW-1:0]     row_i,
  input  logic [LANES*DATA_W-1:0] prod_i,
  output logic [LANES-1:0]        head_o,
  output logic [LANES*DATA_W-1:0] sum_o
);
  always_comb begin
    head_o = '0;
    sum_o  = '0;
    for (int i = 0; i < LANES; i++) begin
      head_o[i] = vld_i[i];
      for (int j = 0; j < LANES; j++) begin
        if (vld_i[j] && row_i[j*RW +: RW] == row_i[i*RW +: RW]) begin
          sum_o[i*DATA_W +: DATA_W] = sum_o[i*DATA_W +: DATA_W] + prod_i[j*DATA_W +: DATA_W];
          if (j < i) head_o[i] = 1'b0;  // an earlier slot owns this row
        end
      end
    end
  end
endmodule

// File: rtl/spmv_row_accum.sv
module spmv_row_accum
  import spmv_pkg::*;
#(
  parameter int LANES    = 5,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 32,
  parameter int ROWS     = 60,
  parameter int ROW_BASE = 0,
  parameter int SLOTS    = 15,
  parameter int RW       = 6,
  localparam int NW      = ceil_div(ROWS, SLOTS),
  localparam int NTOT    = NW * SLOTS,
  localparam int WW      = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [LANES-1:0]        upd_vld_i,
  input  logic [LANES*RW-1:0]     upd_row_i,
  input  logic [LANES*DATA_W-1:0] upd_sum_i,
  input  logic                    flush_i,
  output logic                    out_valid_o,
  output logic                    out_last_o,
  output logic [IDX_W-1:0]        out_base_o,
  output logic [SLOTS-1:0]        out_mask_o,
  output logic [SLOTS*DATA_W-1:0] out_data_o
);
  logic [DATA_W-1:0] acc_q [NTOT];
  logic [NTOT-1:0]   hit_q;
  wb_state_e         state_q;
  logic [WW-1:0]     w_q;
  logic [RW-1:0]     slot_idx [SLOTS];
  logic [SLOTS-1:0]  w_mask;
  logic              w_final;

  always_comb begin
    for (int k = 0; k < SLOTS; k++) begin
      slot_idx[k] = RW'(int'(w_q) * SLOTS + k);
      w_mask[k]   = hit_q[slot_idx[k]];
    end
  end
  assign w_final = (w_q == WW'(NW - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int n = 0; n < NTOT; n++) acc_q[n] <= '0;
      hit_q       <= '0;
      state_q     <= WB_IDLE;
      w_q         <= '0;
      out_valid_o <= 1'b0;
      out_last_o  <= 1'b0;
      out_base_o  <= '0;
      out_mask_o  <= '0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= 1'b0;
      out_last_o  <= 1'b0;
      if (state_q == WB_RUN) begin
        for (int k = 0; k < SLOTS; k++) begin
          out_data_o[k*DATA_W +: DATA_W] <= acc_q[slot_idx[k]];
          acc_q[slot_idx[k]] <= '0;
          hit_q[slot_idx[k]] <= 1'b0;
        end
        out_mask_o  <= w_mask;
        out_base_o  <= IDX_W'(ROW_BASE) + IDX_W'(int'(w_q) * SLOTS);
        out_valid_o <= (|w_mask) || w_final;
        out_last_o  <= w_final;
        if (w_final) state_q <= WB_IDLE;
        else         w_q     <= w_q + 1'b1;
      end
      for (int i = 0; i < LANES; i++) begin
        if (upd_vld_i[i]) begin
          acc_q[upd_row_i[i*RW +: RW]] <= acc_q[upd_row_i[i*RW +: RW]] + upd_sum_i[i*DATA_W +: DATA_W];
          hit_q[upd_row_i[i*RW +: RW]] <= 1'b1;
        end
      end
      if (flush_i) begin
        state_q <= WB_RUN;
        w_q     <= '0;
      end
    end
  end
endmodule

// File: rtl/spmv_coo_unit.sv
module spmv_coo_unit
  import spmv_pkg::*;
#(
  parameter int LANES     = 5,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 32,
  parameter int VEC_DEPTH = 64,
  parameter int ROWS      = 60,
  parameter int ROW_BASE  = 120,
  parameter int SLOTS     = 15,
  localparam int AW       = $clog2(VEC_DEPTH),
  localparam int NW       = ceil_div(ROWS, SLOTS),
  localparam int RW       = $clog2(NW * SLOTS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    vec_we_i,
  input  logic [AW-1:0]           vec_waddr_i,
  input  logic [DATA_W-1:0]       vec_wdata_i,
  input  logic                    pkt_valid_i,
  input  logic                    pkt_last_i,
  input  logic [LANES-1:0]        pkt_lane_vld_i,
  input  logic [LANES*IDX_W-1:0]  pkt_row_i,
  input  logic [LANES*IDX_W-1:0]  pkt_col_i,
  input  logic [LANES*DATA_W-1:0] pkt_val_i,
  output logic                    out_valid_o,
  output logic                    out_last_o,
  output logic [IDX_W-1:0]        out_base_o,
  output logic [SLOTS-1:0]        out_mask_o,
  output logic [SLOTS*DATA_W-1:0] out_data_o
);
  logic [LANES-1:0]        acc_lane;
  logic [LANES*RW-1:0]     loc_row;
  logic [LANES*AW-1:0]     rd_addr;
  logic [LANES*DATA_W-1:0] x_data, prod, red_sum;
  logic [LANES-1:0]        red_head;

  logic [LANES-1:0]        s1_vld_q;
  logic [LANES*RW-1:0]     s1_row_q;
  logic [LANES*DATA_W-1:0] s1_val_q;
  logic                    s1_last_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [IDX_W-1:0] row_g, col_g;
    assign row_g = pkt_row_i[g*IDX_W +: IDX_W];
    assign col_g = pkt_col_i[g*IDX_W +: IDX_W];
    assign acc_lane[g] = pkt_valid_i && pkt_lane_vld_i[g]
                      && row_g >= IDX_W'(ROW_BASE)
                      && row_g <  IDX_W'(ROW_BASE + ROWS)
                      && col_g <  IDX_W'(VEC_DEPTH);
    assign loc_row[g*RW +: RW] = RW'(row_g - IDX_W'(ROW_BASE));
    assign rd_addr[g*AW +: AW] = col_g[AW-1:0];
    assign prod[g*DATA_W +: DATA_W] = s1_val_q[g*DATA_W +: DATA_W] * x_data[g*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q  <= '0;
      s1_row_q  <= '0;
      s1_val_q  <= '0;
      s1_last_q <= 1'b0;
    end else begin
      s1_vld_q  <= acc_lane;
      s1_row_q  <= loc_row;
      s1_val_q  <= pkt_val_i;
      s1_last_q <= pkt_valid_i && pkt_last_i;
    end
  end

  spmv_vec_replicas #(.LANES(LANES), .DATA_W(DATA_W), .DEPTH(VEC_DEPTH)) i_vec (
    .clk_i   (clk_i),
    .we_i    (vec_we_i),
    .waddr_i (vec_waddr_i),
    .wdata_i (vec_wdata_i),
    .raddr_i (rd_addr),
    .rdata_o (x_data)
  );

  spmv_lane_reduce #(.LANES(LANES), .DATA_W(DATA_W), .RW(RW)) i_reduce (
    .vld_i  (s1_vld_q),
    .row_i  (s1_row_q),
    .prod_i (prod),
    .head_o (red_head),
    .sum_o  (red_sum)
  );

  spmv_row_accum #(
    .LANES(LANES), .DATA_W(DATA_W), .IDX_W(IDX_W), .ROWS(ROWS),
    .ROW_BASE(ROW_BASE), .SLOTS(SLOTS), .RW(RW)
  ) i_accum (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .upd_vld_i   (red_head),
    .upd_row_i   (s1_row_q),
    .upd_sum_i   (red_sum),
    .flush_i     (s1_last_q),
    .out_valid_o (out_valid_o),
    .out_last_o  (out_last_o),
    .out_base_o  (out_base_o),
    .out_mask_o  (out_mask_o),
    .out_data_o  (out_data_o)
  );
endmodule

// File: rtl/spmv_coo_unit_chk.sv
module spmv_coo_unit_chk #(
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 32,
  parameter int ROW_BASE = 0,
  parameter int SLOTS    = 15
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    out_valid_o,
  input logic                    out_last_o,
  input logic [IDX_W-1:0]        out_base_o,
  input logic [SLOTS-1:0]        out_mask_o,
  input logic [SLOTS*DATA_W-1:0] out_data_o
);
  // R9
  last_has_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o);
  // R9
  no_empty_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_mask_o != '0) || out_last_o);
  // R10
  gap_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |=> !out_valid_o);
  // R7
  base_ascending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_last_o) |=> (!out_valid_o || out_base_o > $past(out_base_o)));
  // R7
  base_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ((out_base_o - IDX_W'(ROW_BASE)) % IDX_W'(SLOTS)) == '0);
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    // R8
    masked_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && !out_mask_o[k]) |-> out_data_o[k*DATA_W +: DATA_W] == '0);
  end
endmodule

bind spmv_coo_unit spmv_coo_unit_chk #(
  .DATA_W(DATA_W), .IDX_W(IDX_W), .ROW_BASE(ROW_BASE), .SLOTS(SLOTS)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .out_valid_o (out_valid_o),
  .out_last_o  (out_last_o),
  .out_base_o  (out_base_o),
  .out_mask_o  (out_mask_o),
  .out_data_o  (out_data_o)
);

// File: tb/test_spmv_coo_unit.sv
module test_spmv_coo_unit;
  localparam int LANES = 5, DATA_W = 32, IDX_W = 32, VEC_DEPTH = 16;
  localparam int ROWS = 20, ROW_BASE = 8, SLOTS = 15;
  localparam int NW = (ROWS + SLOTS - 1) / SLOTS;
  localparam int AW = $clog2(VEC_DEPTH);

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic vec_we_i = 1'b0;
  logic [AW-1:0] vec_waddr_i = '0;
  logic [DATA_W-1:0] vec_wdata_i = '0;
  logic pkt_valid_i = 1'b0, pkt_last_i = 1'b0;
  logic [LANES-1:0] pkt_lane_vld_i = '0;
  logic [LANES*IDX_W-1:0] pkt_row_i = '0, pkt_col_i = '0;
  logic [LANES*DATA_W-1:0] pkt_val_i = '0;
  logic out_valid_o, out_last_o;
  logic [IDX_W-1:0] out_base_o;
  logic [SLOTS-1:0] out_mask_o;
  logic [SLOTS*DATA_W-1:0] out_data_o;

  spmv_coo_unit #(
    .LANES(LANES), .DATA_W(DATA_W), .IDX_W(IDX_W), .VEC_DEPTH(VEC_DEPTH),
    .ROWS(ROWS), .ROW_BASE(ROW_BASE), .SLOTS(SLOTS)
  ) i_spmv_coo_unit (.*);

  always #5 clk_i = ~clk_i;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [31:0] seed = 32'h1234_5678;
  logic [DATA_W-1:0] xv [VEC_DEPTH];
  logic [DATA_W-1:0] ex_acc [ROWS];
  bit ex_hit [ROWS];
  int l_row [LANES], l_col [LANES];
  logic [DATA_W-1:0] l_val [LANES];
  bit l_vld [LANES];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic load_vec();
    for (int a = 0; a < VEC_DEPTH; a++) begin
      @(negedge clk_i);
      xv[a] = rnd();
      vec_we_i = 1'b1; vec_waddr_i = AW'(a); vec_wdata_i = xv[a];
    end
    @(negedge clk_i);
    vec_we_i = 1'b0;
  endtask

  task automatic send(input bit last);
    @(negedge clk_i);
    pkt_valid_i = 1'b1; pkt_last_i = last;
    for (int i = 0; i < LANES; i++) begin
      pkt_lane_vld_i[i] = l_vld[i];
      pkt_row_i[i*IDX_W +: IDX_W] = IDX_W'(l_row[i]);
      pkt_col_i[i*IDX_W +: IDX_W] = IDX_W'(l_col[i]);
      pkt_val_i[i*DATA_W +: DATA_W] = l_val[i];
      if (l_vld[i] && l_row[i] >= ROW_BASE && l_row[i] < ROW_BASE + ROWS
          && l_col[i] >= 0 && l_col[i] < VEC_DEPTH) begin
        ex_acc[l_row[i] - ROW_BASE] += l_val[i] * xv[l_col[i]];
        ex_hit[l_row[i] - ROW_BASE] = 1'b1;
      end
    end
  endtask

  function automatic bit word_due(input int w);
    bit any = (w == NW - 1);
    for (int k = 0; k < SLOTS; k++)
      if (w * SLOTS + k < ROWS && ex_hit[w * SLOTS + k]) any = 1'b1;
    return any;
  endfunction

  // ends the stream (last packet already sent) and checks every word
  task automatic drain(input string req);
    int ew = 0, seen = 0, due = 0, t = 0;
    bit fin = 1'b0;
    @(negedge clk_i);
    pkt_valid_i = 1'b0; pkt_last_i = 1'b0; pkt_lane_vld_i = '0;
    for (int w = 0; w < NW; w++) if (word_due(w)) due++;
    while (!fin && t < 50) begin
      @(negedge clk_i);
      t++;
      if (out_valid_o) begin
        logic [SLOTS-1:0] em = '0;
        logic [SLOTS*DATA_W-1:0] ed = '0;
        seen++;
        while (ew < NW - 1 && !word_due(ew)) ew++;
        for (int k = 0; k < SLOTS; k++) begin
          int r = ew * SLOTS + k;
          if (r < ROWS && ex_hit[r]) begin
            em[k] = 1'b1;
            ed[k*DATA_W +: DATA_W] = ex_acc[r];
          end
        end
        check(out_base_o == IDX_W'(ROW_BASE + ew * SLOTS), "R7 base", 64'(out_base_o), 64'(ROW_BASE + ew * SLOTS));
        check(out_mask_o == em, "R8 mask", 64'(out_mask_o), 64'(em));
        for (int k = 0; k < SLOTS; k++)
          check(out_data_o[k*DATA_W +: DATA_W] == ed[k*DATA_W +: DATA_W], req,
                64'(out_data_o[k*DATA_W +: DATA_W]), 64'(ed[k*DATA_W +: DATA_W]));
        check(out_last_o == (ew == NW - 1), "R9 last", 64'(out_last_o), 64'(ew == NW - 1));
        if (out_last_o) fin = 1'b1;
        ew++;
      end
    end
    check(seen == due, "R9 word count", 64'(seen), 64'(due));
    for (int r = 0; r < ROWS; r++) begin ex_acc[r] = '0; ex_hit[r] = 1'b0; end
  endtask

  task automatic clear_lanes();
    for (int i = 0; i < LANES; i++) begin
      l_vld[i] = 1'b0; l_row[i] = ROW_BASE; l_col[i] = 0; l_val[i] = '0;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < ROWS; r++) begin ex_acc[r] = '0; ex_hit[r] = 1'b0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R11
    check(!out_valid_o && !out_last_o, "R11 reset", 64'({out_valid_o, out_last_o}), 64'd0);
    load_vec();

    // R1 R2 R6: distinct rows, distinct columns per slot, several packets
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < LANES; i++) begin
        l_vld[i] = 1'b1; l_row[i] = ROW_BASE + (p * 5 + i) % ROWS;
        l_col[i] = (p * 7 + i * 3) % VEC_DEPTH; l_val[i] = rnd();
      end
      send(p == 3);
    end
    drain("R1 R2 R6 data");

    // R3: all slots on one row, repeated across packets
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < LANES; i++) begin
        l_vld[i] = 1'b1; l_row[i] = ROW_BASE + 4; l_col[i] = i + p; l_val[i] = rnd();
      end
      send(p == 2);
    end
    drain("R3 data");

    // R4: padding slots carry live-looking rows and values
    clear_lanes();
    for (int i = 0; i < LANES; i++) begin
      l_row[i] = ROW_BASE + 10 + i; l_col[i] = i; l_val[i] = rnd(); l_vld[i] = (i == 2);
    end
    send(1'b1);
    drain("R4 data");

    // R5: rows and columns outside the partition
    clear_lanes();
    l_vld = '{1, 1, 1, 1, 1};
    l_row = '{ROW_BASE - 1, ROW_BASE + ROWS, ROW_BASE, ROW_BASE + ROWS - 1, ROW_BASE + 3};
    l_col = '{1, 2, 3, 4, VEC_DEPTH};
    for (int i = 0; i < LANES; i++) l_val[i] = rnd();
    send(1'b1);
    drain("R5 data");

    // R9: only the upper word touched, then an empty stream
    clear_lanes();
    l_vld[0] = 1'b1; l_row[0] = ROW_BASE + SLOTS + 1; l_col[0] = 5; l_val[0] = 32'd7;
    send(1'b1);
    drain("R9 data");
    clear_lanes();
    send(1'b1);
    drain("R9 empty");

    // R10 R2: pseudo-random sweep, vector reloaded now and then
    for (int s = 0; s < 40; s++) begin
      int np = 1 + int'(rnd() % 6);
      if (s % 10 == 9) load_vec();
      for (int p = 0; p < np; p++) begin
        for (int i = 0; i < LANES; i++) begin
          l_vld[i] = (rnd() % 5) != 0;
          l_row[i] = ROW_BASE - 2 + int'(rnd() % (ROWS + 4));
          l_col[i] = int'(rnd() % (VEC_DEPTH + 1));
          l_val[i] = rnd();
        end
        send(p == np - 1);
      end
      drain("R10 R2 sweep");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule